// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Unit

This unit performs the signed multiply and multiply-accumulate operations used by a DSP-capable integer pipeline. It takes two source words, selects a signed 16-bit half of each (or, for the word forms, keeps the whole first word), forms the product, and optionally adds it to a 32-bit or 64-bit accumulator. For the 32-bit accumulate forms, it also raises a request to set the core's sticky overflow flag.

The operation is issued with a single-cycle `in_valid` pulse carrying an opcode, two halfword select bits, the two source words and the accumulator words. The result appears on registered outputs exactly one clock later. The flag output is a set request only: the core ORs it into its sticky flag and never clears the flag from this unit. On overflow the wrapped sum is returned unsaturated. If the DSP extension is disabled, or the opcode is unassigned, the unit reports an undefined-operation indication in place of a result.

Top module: `hmac_unit`

## Requirements
- R1: A select bit of 1 takes bits 31:16 of its source word, and 0 takes bits 15:0. The chosen half is sign-extended as a signed 16-bit value; `sel_a` applies to `src_a` and `sel_b` applies to `src_b`.
- R2: Opcode 0 (half multiply) returns the signed 32-bit product of the two selected halves on `out_lo`, with `out_hi` zero and no flag request.
- R3: Opcode 1 (half accumulate) returns `acc_lo` plus the half product, wrapped to 32 bits. It asserts `out_q_set` exactly when the signed addition overflows, that is, when the operands share a sign and the sum's sign differs. `out_hi` is zero.
- R4: Opcode 2 (long accumulate) adds the sign-extended half product to the 64-bit value {`acc_hi`,`acc_lo`} and returns the upper half on `out_hi` and the lower half on `out_lo`. It never requests the flag.
- R5: Opcode 3 (word multiply) multiplies the full signed `src_a` by the selected signed half of `src_b` and returns bits 47:16 of the 48-bit product, with no flag request.
- R6: Opcode 4 (word accumulate) adds the R5 value to `acc_lo`, wrapped to 32 bits. It asserts `out_q_set` on signed overflow under the same rule as R3.
- R7: When `dsp_en` is low, or the opcode is 5, 6 or 7, an issued operation produces `out_undef`=1 with `out_lo`=`out_hi`=0 and no flag request.
- R8: `out_valid` rises in the cycle after the issue cycle and lasts one cycle. In a cycle that follows a non-issue cycle, `out_valid`, `out_undef` and `out_q_set` are all 0.
- R9: After reset every output is 0.
- R10: For opcodes 3 and 4, `sel_a` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_en | input | 1 | DSP extension present/enabled |
| in_valid | input | 1 | Issue strobe |
| op | input | 3 | Opcode (0..4 valid) |
| sel_a | input | 1 | Upper/lower half select for src_a |
| sel_b | input | 1 | Upper/lower half select for src_b |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| acc_lo | input | 32 | 32-bit accumulator, or low word of 64-bit accumulator |
| acc_hi | input | 32 | High word of 64-bit accumulator |
| out_valid | output | 1 | Result valid |
| out_undef | output | 1 | Undefined-operation indication |
| out_q_set | output | 1 | Request to set the sticky overflow flag |
| out_lo | output | 32 | Result, or low word of the long result |
| out_hi | output | 32 | High word of the long result, else 0 |

## Verification
The bench builds the unit with the default `DATA_W` of 32, so the 16-bit halves, the 48-bit word product window and the 64-bit long sum all have their true widths. At this width, random words land on both signs of every halfword. The directed cases also reach the extreme corners: the most negative halves squared, a full-scale word times the most negative half, carries across the 64-bit halves, and overflow of the 32-bit sum in both the positive and the negative direction.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HMUL  = 3'd0,
        OP_HACC  = 3'd1,
        OP_HLONG = 3'd2,
        OP_WMUL  = 3'd3,
        OP_WACC  = 3'd4
    } hmac_op_e;

    function automatic logic op_is_word(input logic [OP_W-1:0] code);
        return (code == OP_WMUL) || (code == OP_WACC);
    endfunction
endpackage

// File: rtl/hmac_half_pick.sv
module hmac_half_pick #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              upper_i,
    output logic [DATA_W-1:0] ext_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] half_d;

    always_comb begin
        half_d = upper_i ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];
        ext_o  = {{(DATA_W - HALF_W){half_d[HALF_W-1]}}, half_d};
    end
endmodule

// File: rtl/hmac_mult.sv
module hmac_mult #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] ext_a_i,
    input  logic [DATA_W-1:0] ext_b_i,
    input  logic [DATA_W-1:0] word_a_i,
    output logic [DATA_W-1:0] half_prod_o,
    output logic [DATA_W-1:0] word_top_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int WIDE_W = DATA_W + HALF_W;

    logic signed [DATA_W-1:0] half_prod_d;
    logic signed [WIDE_W-1:0] wide_prod_d;

    always_comb begin
        half_prod_d = $signed(ext_a_i) * $signed(ext_b_i);
        wide_prod_d = $signed({{HALF_W{word_a_i[DATA_W-1]}}, word_a_i})
                    * $signed({{HALF_W{ext_b_i[DATA_W-1]}}, ext_b_i});
        half_prod_o = half_prod_d;
        word_top_o  = wide_prod_d[WIDE_W-1:HALF_W];
        // R5: a zero halfword multiplier gives a zero 48-bit product
        assert_word_zero_R5: assert (ext_b_i != '0 || wide_prod_d == '0);
    end
endmodule

// File: rtl/hmac_sum.sv
module hmac_sum #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   prod_i,
    input  logic [DATA_W-1:0]   acc_lo_i,
    input  logic [DATA_W-1:0]   acc_hi_i,
    output logic [DATA_W-1:0]   sum_o,
    output logic                ovf_o,
    output logic [2*DATA_W-1:0] long_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        sum_o  = acc_lo_i + prod_i;
        ovf_o  = (acc_lo_i[MSB] == prod_i[MSB]) && (sum_o[MSB] != acc_lo_i[MSB]);
        long_o = {acc_hi_i, acc_lo_i} + {{DATA_W{prod_i[MSB]}}, prod_i};
    end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
    import hmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsp_en,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] acc_lo,
    input  logic [DATA_W-1:0] acc_hi,
    output logic              out_valid,
    output logic              out_undef,
    output logic              out_q_set,
    output logic [DATA_W-1:0] out_lo,
    output logic [DATA_W-1:0] out_hi
);
    localparam int LONG_W = 2 * DATA_W;

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic              qset;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } res_t;

    res_t res_d, res_q;

    logic [DATA_W-1:0] ext_a, ext_b, half_prod, word_top, prod_sel;
    logic [DATA_W-1:0] sum32;
    logic              ovf32;
    logic [LONG_W-1:0] sum64;
    logic              legal;

    hmac_half_pick #(.DATA_W(DATA_W)) u_pick_a (
        .word_i(src_a), .upper_i(sel_a), .ext_o(ext_a));
    hmac_half_pick #(.DATA_W(DATA_W)) u_pick_b (
        .word_i(src_b), .upper_i(sel_b), .ext_o(ext_b));

    hmac_mult #(.DATA_W(DATA_W)) u_mult (
        .ext_a_i(ext_a), .ext_b_i(ext_b), .word_a_i(src_a),
        .half_prod_o(half_prod), .word_top_o(word_top));

    // one adder serves both accumulate widths: the product is chosen first
    assign prod_sel = op_is_word(op) ? word_top : half_prod;

    hmac_sum #(.DATA_W(DATA_W)) u_sum (
        .prod_i(prod_sel), .acc_lo_i(acc_lo), .acc_hi_i(acc_hi),
        .sum_o(sum32), .ovf_o(ovf32), .long_o(sum64));

    assign legal = dsp_en && (op <= OP_WACC);

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        res_d.undef = 1'b0;
        res_d.qset  = 1'b0;
        if (in_valid) begin
            res_d.hi = '0;
            res_d.lo = '0;
            if (!legal) begin
                res_d.undef = 1'b1;
            end else begin
                case (op)
                    OP_HMUL:  res_d.lo = half_prod;
                    OP_HACC:  begin res_d.lo = sum32; res_d.qset = ovf32; end
                    OP_HLONG: begin
                        res_d.lo = sum64[DATA_W-1:0];
                        res_d.hi = sum64[LONG_W-1:DATA_W];
                    end
                    OP_WMUL:  res_d.lo = word_top;
                    OP_WACC:  begin res_d.lo = sum32; res_d.qset = ovf32; end
                    default:  res_d.undef = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_undef = res_q.undef;
    assign out_q_set = res_q.qset;
    assign out_lo    = res_q.lo;
    assign out_hi    = res_q.hi;

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_undef && !out_q_set));
    assert_undef_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dsp_en) |=> (out_undef && !out_q_set && out_lo == '0 && out_hi == '0));
    assert_no_q_hmul_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_HMUL) |=> !out_q_set);
    assert_no_q_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_HLONG) |=> !out_q_set);
    assert_no_q_wmul_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_WMUL) |=> !out_q_set);
    assert_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_HLONG) |=> (out_hi == '0));
endmodule

// File: tb/tb_hmac_unit.sv
module tb_hmac_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dsp_en = 1'b1;
    logic in_valid = 1'b0;
    logic [2:0] op = '0;
    logic sel_a = 1'b0, sel_b = 1'b0;
    logic [DW-1:0] src_a = '0, src_b = '0, acc_lo = '0, acc_hi = '0;
    logic out_valid, out_undef, out_q_set;
    logic [DW-1:0] out_lo, out_hi;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hmac_unit #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .dsp_en(dsp_en), .in_valid(in_valid), .op(op),
        .sel_a(sel_a), .sel_b(sel_b), .src_a(src_a), .src_b(src_b),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .out_valid(out_valid),
        .out_undef(out_undef), .out_q_set(out_q_set), .out_lo(out_lo), .out_hi(out_hi));

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic longint half_of(input logic [31:0] w, input logic hi);
        logic [15:0] h;
        h = hi ? w[31:16] : w[15:0];
        return longint'($signed(h));
    endfunction

    // reference model: {undef, q, hi, lo}
    task automatic model(input logic en, input logic [2:0] o, input logic sa, input logic sb,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] al, input logic [31:0] ah,
                         output logic e_undef, output logic e_q,
                         output logic [31:0] e_lo, output logic [31:0] e_hi);
        longint p, s;
        logic [63:0] l;
        e_undef = 1'b0; e_q = 1'b0; e_lo = '0; e_hi = '0;
        if (!en || o > 3'd4) begin
            e_undef = 1'b1;
            return;
        end
        if (o == 3'd3 || o == 3'd4) p = (longint'($signed(a)) * half_of(b, sb)) >>> 16;
        else                        p = half_of(a, sa) * half_of(b, sb);
        p = longint'($signed(p[31:0]));
        case (o)
            3'd0, 3'd3: e_lo = p[31:0];
            3'd1, 3'd4: begin
                s = longint'($signed(al)) + p;
                e_lo = s[31:0];
                e_q = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            default: begin
                l = {ah, al} + 64'(p);
                e_lo = l[31:0];
                e_hi = l[63:32];
            end
        endcase
    endtask

    task automatic issue(input string tag, input logic en, input logic [2:0] o,
                         input logic sa, input logic sb, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] al, input logic [31:0] ah);
        logic eu, eq;
        logic [31:0] el, eh;
        model(en, o, sa, sb, a, b, al, ah, eu, eq, el, eh);
        @(negedge clk);
        dsp_en = en; op = o; sel_a = sa; sel_b = sb;
        src_a = a; src_b = b; acc_lo = al; acc_hi = ah; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "valid", 64'(out_valid), 64'd1);
        check(tag, "lo", 64'(out_lo), 64'(el));
        check(tag, "hi", 64'(out_hi), 64'(eh));
        check(tag, "q", 64'(out_q_set), 64'(eq));
        check(tag, "undef", 64'(out_undef), 64'(eu));
    endtask

    initial begin
        logic [31:0] r_first;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "valid", 64'(out_valid), 64'd0);
        check("R9", "lo", 64'(out_lo), 64'd0);
        check("R9", "hi", 64'(out_hi), 64'd0);
        check("R9", "q", 64'(out_q_set), 64'd0);
        rst_n = 1'b1;

        // R1 / R2 directed: halves and sign extension
        issue("R1", 1, 3'd0, 1, 0, 32'h8000_0003, 32'h0002_FFFF, 0, 0);
        issue("R2", 1, 3'd0, 0, 1, 32'h1234_8000, 32'h8000_0000, 0, 0);
        issue("R2", 1, 3'd0, 1, 1, 32'h7FFF_0000, 32'h7FFF_0000, 0, 0);
        // R3 overflow both directions and no-overflow
        issue("R3", 1, 3'd1, 0, 0, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 0);
        issue("R3", 1, 3'd1, 0, 0, 32'h0000_FFFF, 32'h0000_0001, 32'h8000_0000, 0);
        issue("R3", 1, 3'd1, 0, 0, 32'h0000_0003, 32'h0000_0004, 32'h0000_0010, 0);
        // R4 carry and borrow across halves
        issue("R4", 1, 3'd2, 0, 0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0005);
        issue("R4", 1, 3'd2, 0, 0, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001);
        issue("R4", 1, 3'd2, 0, 0, 32'h0000_7FFF, 32'h0000_7FFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
        // R5 extreme word product
        issue("R5", 1, 3'd3, 0, 0, 32'h8000_0000, 32'h0000_8000, 0, 0);
        issue("R5", 1, 3'd3, 0, 1, 32'hFFFF_FFFF, 32'h0001_0000, 0, 0);
        // R6 word accumulate overflow
        issue("R6", 1, 3'd4, 0, 0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_0000, 0);
        // R7 undefined
        issue("R7", 0, 3'd1, 0, 0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0);
        issue("R7", 1, 3'd6, 1, 1, 32'h1111_2222, 32'h3333_4444, 1, 2);
        // R8 idle cycle after issue
        @(negedge clk);
        check("R8", "idle valid", 64'(out_valid), 64'd0);
        check("R8", "idle q", 64'(out_q_set), 64'd0);
        check("R8", "idle undef", 64'(out_undef), 64'd0);
        // R10 sel_a ignored in word forms
        issue("R10", 1, 3'd3, 0, 1, 32'h9ABC_DEF0, 32'h8001_0000, 0, 0);
        r_first = out_lo;
        issue("R10", 1, 3'd3, 1, 1, 32'h9ABC_DEF0, 32'h8001_0000, 0, 0);
        check("R10", "sel_a effect", 64'(out_lo), 64'(r_first));
        issue("R10", 1, 3'd4, 1, 0, 32'h4000_0000, 32'h0000_4000, 32'h7000_0000, 0);
        // constrained random across all opcodes
        for (int i = 0; i < 400; i++) begin
            logic [2:0] ro;
            ro = 3'($urandom_range(0, 4));
            if ($urandom_range(0, 19) == 0) ro = 3'($urandom_range(5, 7));
            issue(ro == 3'd0 ? "R2" : ro == 3'd1 ? "R3" : ro == 3'd2 ? "R4" :
                  ro == 3'd3 ? "R5" : ro == 3'd4 ? "R6" : "R7",
                  ($urandom_range(0, 15) != 0), ro, 1'($urandom), 1'($urandom),
                  $urandom, $urandom, $urandom, $urandom);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule